// File: doc/BRIEF.md
# Pointer and Bounds Check Trap Unit

This block evaluates the checking instructions of a word-oriented stack machine against the top stack entries. It accepts one opcode per cycle, together with the top-of-stack word, the word below it, and the high half of the data-space base. One cycle later it reports the stack effect the operation needs, or raises a coded trap if the check fails.

Four operations are handled. A single-word nil test traps on a zero pointer. A two-word nil test traps only when both halves of a long pointer are zero. An unsigned bounds test traps when the index is not below the limit, and drops the limit if the test passes. Pointer lengthening turns a short pointer into a two-word long pointer. A small block of undefined opcodes always traps, and a parameter chooses how the opcode is reported. Other opcodes are ignored. Stack storage and trap dispatch belong to the surrounding datapath.

Top module: `ptr_check_unit`

## Requirements
- R1: While reset is asserted, and until the first accepted operation after it, every output is zero.
- R2: Opcode 8'o171 (0x79) with `tos` equal to zero traps with `CODE_PTR_FAULT`. With nonzero `tos` it completes without trap, popping 0 words and pushing 0 words.
- R3: Opcode 8'o172 (0x7A) traps with `CODE_PTR_FAULT` only when `tos | nos` is zero. Otherwise it completes, popping 0 words and pushing 0 words.
- R4: Opcode 8'o173 (0x7B) traps with `CODE_BOUNDS_FAULT` when `nos >= tos`, compared unsigned. Otherwise it completes with `pop_cnt` = 1 and `push_cnt` = 0.
- R5: Opcode 8'o161 (0x71) never traps. It reports `pop_cnt` = 1 and `push_cnt` = 2, with `push_w0` (pushed first) equal to `tos`. `push_w1` is 0 when `tos` is 0, and otherwise `ds_base_hi >> 8`.
- R6: Opcodes 8'o174 to 8'o177 (0x7C to 0x7F) always trap. With `UNDEF_AS_INDEX` = 0, `trap_code` is `CODE_UNIMPL` and `trap_parm` is the opcode. With `UNDEF_AS_INDEX` = 1, `trap_code` is the opcode and `trap_parm` is 0.
- R7: The results of an operation presented with `op_valid` appear at the next rising clock edge and last exactly one cycle. Back-to-back operations give back-to-back results.
- R8: In a cycle with `trap_stb` high, `pop_cnt`, `push_cnt`, `push_w0` and `push_w1` are all zero.
- R9: Any other opcode, or any cycle with `op_valid` low, leaves `out_valid` and `trap_stb` low and all other outputs zero in the following cycle.
- R10: `trap_parm` is zero on every trap except an undefined-opcode trap with `UNDEF_AS_INDEX` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An opcode is presented this cycle |
| opcode | input | 8 | Instruction byte |
| tos | input | W | Top stack word |
| nos | input | W | Stack word below the top |
| ds_base_hi | input | W | High half of the data-space base |
| out_valid | output | 1 | A handled opcode finished (trap or not) |
| trap_stb | output | 1 | One-cycle trap strobe |
| trap_code | output | 8 | Trap code |
| trap_parm | output | 8 | Trap parameter |
| pop_cnt | output | 2 | Words to pop |
| push_cnt | output | 2 | Words to push after the pop |
| push_w0 | output | W | First word pushed |
| push_w1 | output | W | Second word pushed |

## Verification
The bounds test is swept over every pair of index and limit in a 16-value window, plus pairs at the top of the word range. This separates an unsigned compare from a signed one and `>=` from `>`. The nil tests are tried with a single set bit in either word and with the sign bit alone, so a test that looks at one half or at part of the word shows up. Lengthening pairs zero and nonzero pointers with several base patterns, which exposes a wrong shift or a missing zero case. A sweep of all 256 opcodes shows that only the intended codes respond, and a second instance checks the other undefined-opcode reporting mode.

// File: rtl/ptrchk_pkg.sv
package ptrchk_pkg;

    localparam logic [7:0] OP_LENGTHEN = 8'o161;
    localparam logic [7:0] OP_NIL      = 8'o171;
    localparam logic [7:0] OP_NIL_LONG = 8'o172;
    localparam logic [7:0] OP_BOUNDS   = 8'o173;
    localparam logic [7:0] OP_UNDEF_LO = 8'o174;

    typedef enum logic [2:0] {
        K_NONE,
        K_NIL,
        K_NIL_LONG,
        K_BOUNDS,
        K_LENGTHEN,
        K_UNDEF
    } op_kind_e;

    typedef enum logic [1:0] {
        F_NONE,
        F_POINTER,
        F_BOUNDS,
        F_UNIMPL
    } fault_e;

endpackage

// File: rtl/ptrchk_decode.sv
module ptrchk_decode
    import ptrchk_pkg::*;
(
    input  logic       op_valid,
    input  logic [7:0] opcode,
    output op_kind_e   kind
);

    always_comb begin
        kind = K_NONE;
        if (op_valid) begin
            if (opcode == OP_LENGTHEN) begin
                kind = K_LENGTHEN;
            end else if (opcode == OP_NIL) begin
                kind = K_NIL;
            end else if (opcode == OP_NIL_LONG) begin
                kind = K_NIL_LONG;
            end else if (opcode == OP_BOUNDS) begin
                kind = K_BOUNDS;
            end else if (opcode[7:2] == OP_UNDEF_LO[7:2]) begin
                kind = K_UNDEF;
            end
        end
    end

endmodule

// File: rtl/ptrchk_test.sv
module ptrchk_test
    import ptrchk_pkg::*;
#(
    parameter int W = 16
) (
    input  op_kind_e       kind,
    input  logic [W-1:0]   tos,
    input  logic [W-1:0]   nos,
    output logic           trap,
    output fault_e         fault
);

    logic tos_zero;
    logic pair_zero;
    logic index_ok;

    assign tos_zero  = (tos == '0);
    assign pair_zero = ((tos | nos) == '0);
    assign index_ok  = (nos < tos);

    always_comb begin
        trap  = 1'b0;
        fault = F_NONE;
        case (kind)
            K_NIL: begin
                trap  = tos_zero;
                fault = tos_zero ? F_POINTER : F_NONE;
            end
            K_NIL_LONG: begin
                trap  = pair_zero;
                fault = pair_zero ? F_POINTER : F_NONE;
            end
            K_BOUNDS: begin
                trap  = !index_ok;
                fault = index_ok ? F_NONE : F_BOUNDS;
            end
            K_UNDEF: begin
                trap  = 1'b1;
                fault = F_UNIMPL;
            end
            default: begin
                trap  = 1'b0;
                fault = F_NONE;
            end
        endcase
    end

endmodule

// File: rtl/ptrchk_lengthen.sv
module ptrchk_lengthen #(
    parameter int W         = 16,
    parameter int LEN_SHIFT = 8
) (
    input  logic [W-1:0] short_ptr,
    input  logic [W-1:0] base_hi,
    output logic [W-1:0] high_word
);

    logic [W-1:0] base_shifted;

    assign base_shifted = base_hi >> LEN_SHIFT;

    always_comb begin
        if (short_ptr == '0) begin
            high_word = '0;
        end else begin
            high_word = base_shifted;
        end
    end

endmodule

// File: rtl/ptr_check_unit.sv
module ptr_check_unit
    import ptrchk_pkg::*;
#(
    parameter int         W                 = 16,
    parameter int         LEN_SHIFT         = 8,
    parameter logic [7:0] CODE_PTR_FAULT    = 8'h02,
    parameter logic [7:0] CODE_BOUNDS_FAULT = 8'h03,
    parameter logic [7:0] CODE_UNIMPL       = 8'h01,
    parameter bit         UNDEF_AS_INDEX    = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [7:0]   opcode,
    input  logic [W-1:0] tos,
    input  logic [W-1:0] nos,
    input  logic [W-1:0] ds_base_hi,
    output logic         out_valid,
    output logic         trap_stb,
    output logic [7:0]   trap_code,
    output logic [7:0]   trap_parm,
    output logic [1:0]   pop_cnt,
    output logic [1:0]   push_cnt,
    output logic [W-1:0] push_w0,
    output logic [W-1:0] push_w1
);

    typedef struct packed {
        logic         valid;
        logic         trap;
        logic [7:0]   code;
        logic [7:0]   parm;
        logic [1:0]   pop;
        logic [1:0]   push;
        logic [W-1:0] w0;
        logic [W-1:0] w1;
    } result_t;

    op_kind_e     kind;
    logic         trap_hit;
    fault_e       fault;
    logic [W-1:0] long_hi;
    logic [7:0]   undef_code;
    logic [7:0]   undef_parm;
    result_t      res_d;
    result_t      res_q;

    ptrchk_decode u_decode (
        .op_valid (op_valid),
        .opcode   (opcode),
        .kind     (kind)
    );

    ptrchk_test #(.W(W)) u_test (
        .kind  (kind),
        .tos   (tos),
        .nos   (nos),
        .trap  (trap_hit),
        .fault (fault)
    );

    ptrchk_lengthen #(.W(W), .LEN_SHIFT(LEN_SHIFT)) u_len (
        .short_ptr (tos),
        .base_hi   (ds_base_hi),
        .high_word (long_hi)
    );

    generate
        if (UNDEF_AS_INDEX) begin : g_undef_index
            assign undef_code = opcode;
            assign undef_parm = 8'h00;
        end else begin : g_undef_generic
            assign undef_code = CODE_UNIMPL;
            assign undef_parm = opcode;
        end
    endgenerate

    always_comb begin
        res_d       = '0;
        res_d.valid = (kind != K_NONE);
        if (trap_hit) begin
            res_d.trap = 1'b1;
            case (fault)
                F_POINTER: res_d.code = CODE_PTR_FAULT;
                F_BOUNDS:  res_d.code = CODE_BOUNDS_FAULT;
                F_UNIMPL: begin
                    res_d.code = undef_code;
                    res_d.parm = undef_parm;
                end
                default:   res_d.code = 8'h00;
            endcase
        end else begin
            case (kind)
                K_BOUNDS: begin
                    res_d.pop = 2'd1;
                end
                K_LENGTHEN: begin
                    res_d.pop  = 2'd1;
                    res_d.push = 2'd2;
                    res_d.w0   = tos;
                    res_d.w1   = long_hi;
                end
                default: begin
                    res_d.pop  = 2'd0;
                    res_d.push = 2'd0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign trap_stb  = res_q.trap;
    assign trap_code = res_q.code;
    assign trap_parm = res_q.parm;
    assign pop_cnt   = res_q.pop;
    assign push_cnt  = res_q.push;
    assign push_w0   = res_q.w0;
    assign push_w1   = res_q.w1;

endmodule

// File: rtl/ptr_check_unit_chk.sv
module ptr_check_unit_chk
    import ptrchk_pkg::*;
#(
    parameter int         W                 = 16,
    parameter logic [7:0] CODE_PTR_FAULT    = 8'h02,
    parameter logic [7:0] CODE_BOUNDS_FAULT = 8'h03
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [7:0]   opcode,
    input logic [W-1:0] tos,
    input logic [W-1:0] nos,
    input logic         out_valid,
    input logic         trap_stb,
    input logic [7:0]   trap_code,
    input logic [7:0]   trap_parm,
    input logic [1:0]   pop_cnt,
    input logic [1:0]   push_cnt,
    input logic [W-1:0] push_w0,
    input logic [W-1:0] push_w1
);

    // R8
    trap_no_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_stb |-> (pop_cnt == 2'd0 && push_cnt == 2'd0 && push_w0 == '0 && push_w1 == '0));

    // R7
    trap_is_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_stb |-> out_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!out_valid && !trap_stb));

    // R9
    low_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode < OP_LENGTHEN) |=> !out_valid);

    // R2
    nil_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_NIL && tos == '0) |=>
        (trap_stb && trap_code == CODE_PTR_FAULT && trap_parm == 8'h00));

    // R4
    bounds_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_BOUNDS && nos >= tos) |=>
        (trap_stb && trap_code == CODE_BOUNDS_FAULT));

    // R4
    bounds_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_BOUNDS && nos < tos) |=>
        (out_valid && !trap_stb && pop_cnt == 2'd1 && push_cnt == 2'd0));

    // R5
    lengthen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_LENGTHEN) |=>
        (!trap_stb && pop_cnt == 2'd1 && push_cnt == 2'd2 && push_w0 == $past(tos)));

endmodule

bind ptr_check_unit ptr_check_unit_chk #(
    .W                 (W),
    .CODE_PTR_FAULT    (CODE_PTR_FAULT),
    .CODE_BOUNDS_FAULT (CODE_BOUNDS_FAULT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .opcode    (opcode),
    .tos       (tos),
    .nos       (nos),
    .out_valid (out_valid),
    .trap_stb  (trap_stb),
    .trap_code (trap_code),
    .trap_parm (trap_parm),
    .pop_cnt   (pop_cnt),
    .push_cnt  (push_cnt),
    .push_w0   (push_w0),
    .push_w1   (push_w1)
);

// File: tb/tb_ptr_check_unit.sv
module tb_ptr_check_unit;

    localparam logic [7:0] C_PTR = 8'hA1;
    localparam logic [7:0] C_BND = 8'hB2;
    localparam logic [7:0] C_UNI = 8'hC3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] tos = '0, nos = '0, base = '0;

    logic        ov_a, ts_a, ov_b, ts_b;
    logic [7:0]  tc_a, tp_a, tc_b, tp_b;
    logic [1:0]  pc_a, uc_a, pc_b, uc_b;
    logic [15:0] w0_a, w1_a, w0_b, w1_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ptr_check_unit #(.W(16), .CODE_PTR_FAULT(C_PTR), .CODE_BOUNDS_FAULT(C_BND),
                     .CODE_UNIMPL(C_UNI), .UNDEF_AS_INDEX(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .tos(tos), .nos(nos), .ds_base_hi(base),
        .out_valid(ov_a), .trap_stb(ts_a), .trap_code(tc_a), .trap_parm(tp_a),
        .pop_cnt(pc_a), .push_cnt(uc_a), .push_w0(w0_a), .push_w1(w1_a));

    ptr_check_unit #(.W(16), .CODE_PTR_FAULT(C_PTR), .CODE_BOUNDS_FAULT(C_BND),
                     .CODE_UNIMPL(C_UNI), .UNDEF_AS_INDEX(1'b1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .tos(tos), .nos(nos), .ds_base_hi(base),
        .out_valid(ov_b), .trap_stb(ts_b), .trap_code(tc_b), .trap_parm(tp_b),
        .pop_cnt(pc_b), .push_cnt(uc_b), .push_w0(w0_b), .push_w1(w1_b));

    function automatic logic [53:0] actual(bit alt);
        if (alt) return {ov_b, ts_b, tc_b, tp_b, pc_b, uc_b, w0_b, w1_b};
        return {ov_a, ts_a, tc_a, tp_a, pc_a, uc_a, w0_a, w1_a};
    endfunction

    function automatic logic [53:0] model(logic [7:0] op, logic [15:0] t, logic [15:0] n,
                                          logic [15:0] b, bit alt);
        logic v = 0, tr = 0;
        logic [7:0] c = 0, p = 0;
        logic [1:0] po = 0, pu = 0;
        logic [15:0] a0 = 0, a1 = 0;
        if (op == 8'o171) begin
            v = 1; tr = (t == 0); c = tr ? C_PTR : 8'h00;
        end else if (op == 8'o172) begin
            v = 1; tr = (t == 0 && n == 0); c = tr ? C_PTR : 8'h00;
        end else if (op == 8'o173) begin
            v = 1; tr = ({1'b0, n} >= {1'b0, t});
            if (tr) c = C_BND; else po = 1;
        end else if (op == 8'o161) begin
            v = 1; po = 1; pu = 2; a0 = t; a1 = (t == 0) ? 16'h0 : (b / 16'd256);
        end else if (op >= 8'o174 && op <= 8'o177) begin
            v = 1; tr = 1;
            if (alt) c = op; else begin c = C_UNI; p = op; end
        end
        return {v, tr, c, p, po, pu, a0, a1};
    endfunction

    function automatic string tag_of(logic [7:0] op);
        if (op == 8'o171) return "R2";
        if (op == 8'o172) return "R3";
        if (op == 8'o173) return "R4";
        if (op == 8'o161) return "R5";
        if (op >= 8'o174 && op <= 8'o177) return "R6";
        return "R9";
    endfunction

    task automatic check(string tag, logic [53:0] act, logic [53:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // drive one op, check the result cycle, then check the following idle cycle (R7)
    task automatic run_op(logic [7:0] op, logic [15:0] t, logic [15:0] n, logic [15:0] b,
                          bit check_alt);
        @(negedge clk);
        op_valid = 1; opcode = op; tos = t; nos = n; base = b;
        @(negedge clk);
        op_valid = 0;
        check(tag_of(op), actual(0), model(op, t, n, b, 0));
        if (check_alt) check(tag_of(op), actual(1), model(op, t, n, b, 1));
        @(negedge clk);
        check("R7", actual(0), 54'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", actual(0), 54'h0);
        rst_n = 1;
        @(negedge clk);
        check("R1", actual(0), 54'h0);

        // R2 single nil test
        for (int i = 0; i < 32; i++) run_op(8'o171, 16'(i), 16'h5555, 16'h1234, 0);
        run_op(8'o171, 16'h8000, 16'h0, 16'h0, 0);
        run_op(8'o171, 16'hFFFF, 16'h0, 16'h0, 0);

        // R3 long nil test
        foreach (tos[k]) begin end
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                logic [15:0] vals [5] = '{16'h0, 16'h1, 16'h8000, 16'hFFFF, 16'h0100};
                run_op(8'o172, vals[i], vals[j], 16'h0, 0);
            end
        end

        // R4 unsigned bounds, exhaustive window plus edges
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                run_op(8'o173, 16'(j), 16'(i), 16'h0, 0);
        run_op(8'o173, 16'hFFFF, 16'hFFFF, 16'h0, 0);
        run_op(8'o173, 16'hFFFF, 16'hFFFE, 16'h0, 0);
        run_op(8'o173, 16'h0001, 16'hFFFF, 16'h0, 0);
        run_op(8'o173, 16'h8000, 16'h7FFF, 16'h0, 0);

        // R5 lengthening
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                logic [15:0] tv [4] = '{16'h0, 16'h1, 16'hFFFF, 16'h1234};
                logic [15:0] bv [4] = '{16'h0, 16'hABCD, 16'hFF00, 16'h00FF};
                run_op(8'o161, tv[i], 16'h7777, bv[j], 0);
            end
        end

        // R6 undefined opcodes, both reporting modes
        for (int op = 8'o174; op <= 8'o177; op++) run_op(8'(op), 16'h0, 16'h0, 16'h0, 1);

        // R10 parameter zero on nil and bounds traps; R8 no stack effect on trap
        @(negedge clk);
        op_valid = 1; opcode = 8'o171; tos = 0;
        @(negedge clk);
        op_valid = 0;
        check("R10", {46'h0, tp_a}, 54'h0);
        check("R8", {36'h0, pc_a, uc_a, w0_a[6:0], w1_a[6:0]}, 54'h0);
        @(negedge clk);
        op_valid = 1; opcode = 8'o173; tos = 16'h3; nos = 16'h9;
        @(negedge clk);
        op_valid = 0;
        check("R10", {46'h0, tp_a}, 54'h0);
        check("R8", {50'h0, pc_a, uc_a}, 54'h0);

        // R7 back-to-back operations
        @(negedge clk);
        op_valid = 1; opcode = 8'o161; tos = 16'h0042; nos = 0; base = 16'h3400;
        @(negedge clk);
        check("R7", actual(0), model(8'o161, 16'h0042, 16'h0, 16'h3400, 0));
        opcode = 8'o173; tos = 16'h10; nos = 16'h2;
        @(negedge clk);
        check("R7", actual(0), model(8'o173, 16'h10, 16'h2, 16'h3400, 0));
        opcode = 8'o171; tos = 16'h0;
        @(negedge clk);
        op_valid = 0;
        check("R7", actual(0), model(8'o171, 16'h0, 16'h2, 16'h3400, 0));
        @(negedge clk);
        check("R7", actual(0), 54'h0);

        // R9 opcode sweep: only the handled codes respond
        for (int op = 0; op < 256; op++) run_op(8'(op), 16'h0, 16'h0, 16'hFFFF, 0);

        finish_up();
    end

endmodule